// File: doc/BRIEF.md
# Interrupt Distributor Control Registers

This block is the register face of an interrupt distributor. A simple single-cycle 32-bit register bus reaches it; it has a word address, write data, a write strobe and combinational read data. Software uses the block to switch the distributor on or off as a whole and to enable or disable each shared interrupt line. The block also reports its own size and identity through read-only registers.

The control register has one writable bit, the global enable. It also has two status bits that are fixed at one: one says affinity-based routing is on and the other says security is off. The type register is computed from the configured interrupt count. The per-interrupt enables sit in two banks of 32-bit words. Writing a one to a bit in the set bank turns that line on, and writing a one to a bit in the clear bank turns it off. Either bank reads back the current enable state. Word 0 of each bank covers the 32 private lines, which this block does not hold, so it reads as zero and ignores writes.

The block drives out the enable vector and the global enable. Priorities, pending and active state, grouping, and message-based interrupts are handled elsewhere.

Top module: `irqdist_regs`

## Requirements
- R1: After reset, `grp_enable` is 0 and every bit of `irq_enable` is 0.
- R2: Control register at word 0x00. Bit 1 holds the global enable: a write loads it from `bus_wdata[1]`, and a read returns it. Bits 4 and 6 always read 1. All other bits read 0, and writing them has no effect.
- R3: Type register at word 0x01 is read-only. Bits [4:0] = min(NUM_IRQ,1024)/32 − 1. Bits [23:19] = 9, giving a 10-bit ID width. All other bits read 0, which includes CPU count [7:5] and the locality-specific and message-based support bits.
- R4: Identification register at word 0x02 is read-only. Bits [31:24] = PRODUCT_CODE, bits [11:0] = IMPL_CODE, and all other bits are 0.
- R5: Word 0x03 always reads 0xFFFFFFFF and ignores writes.
- R6: Writing the set bank at word 0x40+k, for k in 1..NUM_IRQ/32−1, sets `irq_enable[32k+b]` for each bit b of the write data that is 1.
- R7: Writing the clear bank at word 0x60+k, for k in the same range, clears `irq_enable[32k+b]` for each bit b of the write data that is 1.
- R8: A data bit of 0 written to either bank leaves that enable unchanged. A bank write changes no enable outside the addressed word.
- R9: Word k=0 of both banks reads 0 and ignores writes. `irq_enable[31:0]` is always 0.
- R10: Bank words with k ≥ NUM_IRQ/32 read 0 and ignore writes.
- R11: Reading word k of either bank returns `irq_enable[32k+31:32k]`.
- R12: Any other address reads 0 and ignores writes. Read data is combinational in the same cycle. A write takes effect at the clock edge and can be read back in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_waddr | input | WADDR_W | Word address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed word |
| irq_enable | output | NUM_IRQ | Per-interrupt enable vector |
| grp_enable | output | 1 | Global distributor enable |

## Verification
The main bench instance is built with NUM_IRQ = 96. This makes the type field equal 2 and leaves only bank words 1 and 2 live. Bank words 3 to 31 therefore fall beyond the implemented range and can be tested for read-as-zero/write-ignore. A second instance at NUM_IRQ = 1024 fills every bank word and puts the largest value, 31, in the count field. A behavioural model of the enables is compared on every access against read data, the enable vector and the global enable. The stimulus includes directed edge cases and a long pseudo-random run over all address regions.

// File: rtl/irqdist_regs.sv
module irqdist_regs #(
  parameter int NUM_IRQ = 256,
  parameter int WADDR_W = 8,
  parameter logic [7:0] PRODUCT_CODE = 8'h5A,
  parameter logic [11:0] IMPL_CODE = 12'h3C7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [WADDR_W-1:0] bus_waddr,
  input  logic               bus_wr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic [NUM_IRQ-1:0] irq_enable,
  output logic               grp_enable
);
  localparam int WORDS = NUM_IRQ / 32;
  localparam int CAP = (NUM_IRQ > 1024) ? 1024 : NUM_IRQ;
  localparam logic [4:0] CNT_FIELD = 5'(CAP / 32 - 1);
  localparam logic [31:0] TYPE_VAL = {8'b0, 5'd9, 14'b0, CNT_FIELD};
  localparam logic [31:0] IDENT_VAL = {PRODUCT_CODE, 12'b0, IMPL_CODE};
  localparam int HI_W = WADDR_W - 5;

  logic [4:0]  word;
  logic        sel_set, sel_clr, sel_ctrl;
  logic [31:0] bank_rd;
  logic        grp_q;

  assign word     = bus_waddr[4:0];
  assign sel_set  = bus_waddr[WADDR_W-1:5] == HI_W'(2);
  assign sel_clr  = bus_waddr[WADDR_W-1:5] == HI_W'(3);
  assign sel_ctrl = bus_waddr == WADDR_W'(0);

  always_ff @(posedge clk) begin
    if (!rst_n)                grp_q <= 1'b0;
    else if (bus_wr && sel_ctrl) grp_q <= bus_wdata[1];
  end
  assign grp_enable = grp_q;

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    if (w == 0) begin : g_priv
      assign irq_enable[31:0] = '0;
    end else begin : g_shared
      logic [31:0] q;
      logic        hit;
      assign hit = bus_wr && (word == 5'(w));
      always_ff @(posedge clk) begin
        if (!rst_n)              q <= '0;
        else if (hit && sel_set) q <= q | bus_wdata;
        else if (hit && sel_clr) q <= q & ~bus_wdata;
      end
      assign irq_enable[w*32 +: 32] = q;
    end
  end

  always_comb begin
    bank_rd = '0;
    for (int w = 1; w < WORDS; w++)
      if (word == 5'(w)) bank_rd = irq_enable[w*32 +: 32];
  end

  always_comb begin
    if (sel_set || sel_clr)               bus_rdata = bank_rd;
    else if (sel_ctrl)                    bus_rdata = {25'b0, 1'b1, 1'b0, 1'b1, 2'b0, grp_q, 1'b0};
    else if (bus_waddr == WADDR_W'(1))    bus_rdata = TYPE_VAL;
    else if (bus_waddr == WADDR_W'(2))    bus_rdata = IDENT_VAL;
    else if (bus_waddr == WADDR_W'(3))    bus_rdata = '1;
    else                                  bus_rdata = '0;
  end
endmodule

// File: rtl/irqdist_regs_chk.sv
module irqdist_regs_chk #(
  parameter int NUM_IRQ = 256,
  parameter int WADDR_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic [WADDR_W-1:0] bus_waddr,
  input logic               bus_wr,
  input logic [31:0]        bus_wdata,
  input logic [31:0]        bus_rdata,
  input logic [NUM_IRQ-1:0] irq_enable,
  input logic               grp_enable
);
  localparam int HI_W = WADDR_W - 5;
  localparam logic [NUM_IRQ-1:0] LOWMASK = NUM_IRQ'(32'hFFFF_FFFF);

  logic is_set, is_clr, is_ctrl;
  logic [NUM_IRQ-1:0] wmask;
  assign is_set  = bus_waddr[WADDR_W-1:5] == HI_W'(2);
  assign is_clr  = bus_waddr[WADDR_W-1:5] == HI_W'(3);
  assign is_ctrl = bus_waddr == WADDR_W'(0);
  assign wmask   = NUM_IRQ'(bus_wdata) << (int'(bus_waddr[4:0]) * 32);

  a_r2_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n)
    is_ctrl |-> (bus_rdata[6] && bus_rdata[4] && bus_rdata[1] == grp_enable));
  a_r2_enable_load: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && is_ctrl) |=> grp_enable == $past(bus_wdata[1]));
  a_r2_enable_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && is_ctrl) |=> $stable(grp_enable));
  a_r5_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
    bus_waddr == WADDR_W'(3) |-> bus_rdata == 32'hFFFF_FFFF);
  a_r6_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && is_set) |=> ((irq_enable | LOWMASK) & $past(wmask)) == $past(wmask));
  a_r7_clear_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && is_clr) |=> (irq_enable & $past(wmask)) == '0);
  a_r8_untouched: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && (is_set || is_clr)) |=> ((irq_enable ^ $past(irq_enable)) & ~$past(wmask)) == '0);
  a_r12_no_bank_write: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && (is_set || is_clr)) |=> $stable(irq_enable));
  a_r9_private_zero: assert property (@(posedge clk) disable iff (!rst_n)
    irq_enable[31:0] == 32'h0);
endmodule

bind irqdist_regs irqdist_regs_chk #(.NUM_IRQ(NUM_IRQ), .WADDR_W(WADDR_W)) u_chk (.*);

// File: tb/test_irqdist_regs.sv
module test_irqdist_regs;
  localparam int N = 96;
  logic clk = 0, rst_n = 0, bus_wr = 0;
  logic [7:0] bus_waddr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata, rdata_big;
  logic [N-1:0] irq_enable;
  logic [1023:0] en_big;
  logic grp_enable, grp_big;
  int checks = 0, errors = 0;
  logic [N-1:0] m_en = '0;
  logic m_grp = 0;
  string wtag = "R1";

  always #5 clk = ~clk;

  irqdist_regs #(.NUM_IRQ(N)) i_irqdist_regs (.clk, .rst_n, .bus_waddr, .bus_wr,
    .bus_wdata, .bus_rdata, .irq_enable, .grp_enable);
  irqdist_regs #(.NUM_IRQ(1024)) i_big (.clk, .rst_n, .bus_waddr(8'h01), .bus_wr(1'b0),
    .bus_wdata(32'h0), .bus_rdata(rdata_big), .irq_enable(en_big), .grp_enable(grp_big));

  function automatic logic [31:0] exp_read(logic [7:0] a);
    int k = int'(a[4:0]);
    if (a[7:5] == 3'd2 || a[7:5] == 3'd3) begin
      if (k == 0 || k >= N / 32) return 32'h0;
      return m_en[k*32 +: 32];
    end
    case (a)
      8'h00: return {25'b0, 1'b1, 1'b0, 1'b1, 2'b0, m_grp, 1'b0};
      8'h01: return 32'h0048_0002;
      8'h02: return 32'h5A00_03C7;
      8'h03: return 32'hFFFF_FFFF;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string rtag(logic [7:0] a);
    int k = int'(a[4:0]);
    if (a[7:5] == 3'd2 || a[7:5] == 3'd3) return (k == 0) ? "R9" : (k >= N / 32) ? "R10" : "R11";
    case (a)
      8'h00: return "R2";
      8'h01: return "R3";
      8'h02: return "R4";
      8'h03: return "R5";
      default: return "R12";
    endcase
  endfunction

  task automatic check(string tag, logic [1023:0] act, logic [1023:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic acc(logic [7:0] a, logic wr, logic [31:0] d);
    int k = int'(a[4:0]);
    @(negedge clk);
    bus_waddr = a; bus_wr = wr; bus_wdata = d;
    #1;
    check(rtag(a), 1024'(bus_rdata), 1024'(exp_read(a)));
    check(wtag, 1024'(irq_enable), 1024'(m_en));
    check("R2", 1024'(grp_enable), 1024'(m_grp));
    @(posedge clk);
    if (wr) begin
      if (a == 8'h00) m_grp = d[1];
      if (k > 0 && k < N / 32) begin
        if (a[7:5] == 3'd2) m_en[k*32 +: 32] = m_en[k*32 +: 32] | d;
        if (a[7:5] == 3'd3) m_en[k*32 +: 32] = m_en[k*32 +: 32] & ~d;
      end
      wtag = (a[7:5] == 3'd2) ? "R6 R8" : (a[7:5] == 3'd3) ? "R7 R8" : "R12";
    end
  endtask

  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check("R1", 1024'(irq_enable), 1024'(0));
    check("R1", 1024'(grp_enable), 1024'(0));
    check("R3", 1024'(rdata_big), 1024'(32'h0048_001F));
    for (int a = 0; a < 5; a++) acc(8'(a), 0, 0);
    acc(8'h00, 1, 32'hFFFF_FFFF); acc(8'h00, 0, 0);
    acc(8'h00, 1, 32'hFFFF_FFFD); acc(8'h00, 0, 0);
    acc(8'h00, 1, 32'h0000_0002); acc(8'h00, 0, 0);
    acc(8'h01, 1, 32'h1234_5678); acc(8'h02, 1, 32'hFFFF_FFFF);
    acc(8'h03, 1, 32'h0); acc(8'h01, 0, 0); acc(8'h02, 0, 0); acc(8'h03, 0, 0);
    acc(8'h41, 1, 32'hA5A5_0F0F); acc(8'h41, 0, 0); acc(8'h61, 0, 0);
    acc(8'h42, 1, 32'hFFFF_FFFF); acc(8'h62, 1, 32'h0000_FFFF); acc(8'h42, 0, 0);
    acc(8'h41, 1, 32'h0); acc(8'h61, 1, 32'h0); acc(8'h41, 0, 0);
    acc(8'h61, 1, 32'h8000_0001); acc(8'h61, 0, 0);
    acc(8'h40, 1, 32'hFFFF_FFFF); acc(8'h40, 0, 0); acc(8'h60, 1, 32'hFFFF_FFFF); acc(8'h60, 0, 0);
    acc(8'h43, 1, 32'hFFFF_FFFF); acc(8'h43, 0, 0); acc(8'h5F, 1, 32'hFFFF_FFFF);
    acc(8'h5F, 0, 0); acc(8'h63, 1, 32'hFFFF_FFFF); acc(8'h42, 0, 0);
    acc(8'h04, 1, 32'hFFFF_FFFF); acc(8'h04, 0, 0); acc(8'h80, 1, 32'hFFFF_FFFF);
    acc(8'h80, 0, 0); acc(8'hFF, 1, 32'h1); acc(8'hFF, 0, 0);
    for (int i = 0; i < 2000; i++) begin
      logic [7:0] a;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (lfsr[2:0])
        3'd0, 3'd1: a = {3'b010, 2'b00, lfsr[6:4]};
        3'd2, 3'd3: a = {3'b011, 2'b00, lfsr[6:4]};
        3'd4: a = {6'b0, lfsr[8:7]};
        default: a = lfsr[15:8];
      endcase
      acc(a, lfsr[3], {lfsr, lfsr[7:0], lfsr[15:8]} ^ 32'(i * 32'h9E37_79B9));
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule